// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block moves an 8-bit data word and its parity bit between two ports, A and B, in either direction. Each port's input path has its own 9-bit holding register that follows the bus while its load enable is high and keeps its contents while the enable is low. The outgoing parity bit can be passed through unchanged (pass mode) or replaced by parity generated from the source side's held data bits (generate mode). Parity is checked on both sides at all times, and each side reports a mismatch on an active-low error flag.

Tri-state buses are modelled as separate input, output and output-enable signals per port. Two active-low drive requests choose the direction. Requesting both at once is illegal: neither port is driven and a clash flag is raised. When a port is being driven and its own holding register is loading, the register captures the driven word rather than the bus input. The word just sent is therefore checked on the receiving side as well as on the sending side.

The holding registers are clocked by a system clock with a load enable, so the block is fully synchronous. All parity, data and error outputs are combinational from the register contents and the mode inputs.

Top module: `parity_xcvr`

## Requirements
- R1: With a port's load enable (`a_le` / `b_le`) high at a rising clock edge, that port's holding register takes a new 9-bit word. With it low, the register keeps its contents, and the driven data and error flag derived from it do not change.
- R2: With `drv_b_n` low and `drv_a_n` high, port B is driven (`b_oe`=1, `a_oe`=0) from A's register. With `drv_a_n` low and `drv_b_n` high, port A is driven from B's register. With both high, neither port is driven. An undriven port's outputs read 0.
- R3: With both `drv_a_n` and `drv_b_n` low, neither `a_oe` nor `b_oe` is asserted and `oe_clash` is 1. Otherwise `oe_clash` is 0.
- R4: In pass mode (`pass_sel`=1), the driven port carries the source register's 8 data bits and its stored parity bit unchanged.
- R5: In generate mode (`pass_sel`=0), the driven port's parity bit is the XOR of the source register's 8 data bits when `odd_sel`=0 (even parity), and its inverse when `odd_sel`=1 (odd parity). The 9 driven bits then hold an even, or an odd, count of ones respectively.
- R6: Each error flag (`a_err_n`, `b_err_n`) is 0 when its register's 9 bits hold an odd count of ones with `odd_sel`=0, or an even count with `odd_sel`=1, and is 1 otherwise. Both flags work at the same time and in both modes. Parity bit is word bit 8, data bits are 7..0.
- R7: When a port is driven and its load enable is high, its register captures the driven word and ignores the bus input. The port's error flag then checks the outgoing word.
- R8: Reset is synchronous and active low. It clears both registers to zero.
- R9: Driven parity and error flags follow `odd_sel` and `pass_sel` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Port A data received from the bus |
| a_par_in | input | 1 | Port A parity received from the bus |
| a_out | output | 8 | Port A data to drive |
| a_par_out | output | 1 | Port A parity to drive |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 8 | Port B data received from the bus |
| b_par_in | input | 1 | Port B parity received from the bus |
| b_out | output | 8 | Port B data to drive |
| b_par_out | output | 1 | Port B parity to drive |
| b_oe | output | 1 | Port B drive enable |
| drv_a_n | input | 1 | Request to drive port A from B, active low |
| drv_b_n | input | 1 | Request to drive port B from A, active low |
| pass_sel | input | 1 | 1 = pass parity through, 0 = generate parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_le | input | 1 | Port A register load enable |
| b_le | input | 1 | Port B register load enable |
| a_err_n | output | 1 | Port A parity error, active low |
| b_err_n | output | 1 | Port B parity error, active low |
| oe_clash | output | 1 | Both drive requests asserted |

## Verification
Sending a word and checking it on the receiving side can happen together. When B is driven and B's register is loading in the same cycle, the word A sent is captured by B and judged by `b_err_n` one edge later, while `a_err_n` is still judging the received word. The bench provokes this by putting a wrong-parity word on `b_in` during loopback. It then expects `b_err_n` high after the second edge in generate mode, and both flags low in pass mode with bad source parity. The expected values come from the bit count of the words the bench applied.

// File: rtl/parity_xcvr_pkg.sv
// Package: shared types and helpers for the latched parity transceiver.
// Assumes parity bit is the top bit of each held word.
package parity_xcvr_pkg;

    // Direction decode result.
    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_A2B   = 2'd1,
        DIR_B2A   = 2'd2,
        DIR_CLASH = 2'd3
    } xfer_dir_t;

    // Parity bit that completes a data XOR for the selected sense.
    function automatic logic fill_par(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction

endpackage

// File: rtl/pxc_dir.sv
// Direction decoder: turns the two active-low drive requests into
// per-port drive enables and a clash indication.
// Assumes requests are synchronous levels; outputs are combinational.
module pxc_dir
    import parity_xcvr_pkg::*;
(
    input  logic drv_a_n,
    input  logic drv_b_n,
    output logic oe_a,
    output logic oe_b,
    output logic clash
);

    xfer_dir_t dir;

    // Decode request pair into a direction.
    always_comb begin
        unique case ({drv_a_n, drv_b_n})
            2'b10:   dir = DIR_A2B;
            2'b01:   dir = DIR_B2A;
            2'b00:   dir = DIR_CLASH;
            default: dir = DIR_IDLE;
        endcase
    end

    // Drive enables per direction; clash drives nothing.
    always_comb begin
        oe_a  = (dir == DIR_B2A);
        oe_b  = (dir == DIR_A2B);
        clash = (dir == DIR_CLASH);
    end

endmodule

// File: rtl/pxc_latch.sv
// Holding register for one port: loads on a clock edge while enabled,
// holds otherwise. Synchronous active-low reset clears it.
module pxc_latch #(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    // Load or hold the port word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (le)
            q <= d;
    end

endmodule

// File: rtl/pxc_parity.sv
// Parity unit for one held word: generates parity over the data bits
// and flags a mismatch against the held parity bit (active low).
// Assumes parity bit at index DATA_W, data in DATA_W-1..0.
module pxc_parity
    import parity_xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W:0] word,
    input  logic            odd_sel,
    output logic            gen_par,
    output logic            err_n
);

    logic data_xor;

    // Generate parity and compare with the held bit.
    always_comb begin
        data_xor = ^word[DATA_W-1:0];
        gen_par  = fill_par(data_xor, odd_sel);
        err_n    = (gen_par == word[DATA_W]);
    end

endmodule

// File: rtl/parity_xcvr.sv
// Top: bidirectional latched parity transceiver between ports A and B.
// Side index 0 is port A, 1 is port B. Each side's register takes the
// driven word when that side is driven, else its bus input.
// Assumes all inputs are synchronous to clk.
module parity_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    input  logic              a_par_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_par_out,
    output logic              a_oe,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_par_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_par_out,
    output logic              b_oe,
    input  logic              drv_a_n,
    input  logic              drv_b_n,
    input  logic              pass_sel,
    input  logic              odd_sel,
    input  logic              a_le,
    input  logic              b_le,
    output logic              a_err_n,
    output logic              b_err_n,
    output logic              oe_clash
);

    localparam int WORD_W = DATA_W + 1;
    localparam int SIDES  = 2;

    logic [WORD_W-1:0] rx_word [SIDES];
    logic [WORD_W-1:0] held    [SIDES];
    logic [WORD_W-1:0] lat_d   [SIDES];
    logic [WORD_W-1:0] tx_word [SIDES];
    logic              oe      [SIDES];
    logic              le      [SIDES];
    logic              gen     [SIDES];
    logic              err     [SIDES];

    // Gather per-side inputs into arrays.
    always_comb begin
        rx_word[0] = {a_par_in, a_in};
        rx_word[1] = {b_par_in, b_in};
        le[0]      = a_le;
        le[1]      = b_le;
    end

    pxc_dir u_dir (
        .drv_a_n (drv_a_n),
        .drv_b_n (drv_b_n),
        .oe_a    (oe[0]),
        .oe_b    (oe[1]),
        .clash   (oe_clash)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int SRC = SIDES - 1 - s;

        // Outgoing word: source data plus passed or generated parity.
        always_comb begin
            tx_word[s] = '0;
            if (oe[s])
                tx_word[s] = {(pass_sel ? held[SRC][DATA_W] : gen[SRC]),
                              held[SRC][DATA_W-1:0]};
        end

        // Register input: driven word loops back, else the bus input.
        always_comb lat_d[s] = oe[s] ? tx_word[s] : rx_word[s];

        pxc_latch #(.WORD_W(WORD_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (le[s]),
            .d     (lat_d[s]),
            .q     (held[s])
        );

        pxc_parity #(.DATA_W(DATA_W)) u_par (
            .word    (held[s]),
            .odd_sel (odd_sel),
            .gen_par (gen[s]),
            .err_n   (err[s])
        );
    end

    // Map side arrays back to ports.
    always_comb begin
        {a_par_out, a_out} = tx_word[0];
        {b_par_out, b_out} = tx_word[1];
        a_oe    = oe[0];
        b_oe    = oe[1];
        a_err_n = err[0];
        b_err_n = err[1];
    end

endmodule

// File: rtl/parity_xcvr_chk.sv
// Checker for parity_xcvr: port-level temporal properties, bound below.
module parity_xcvr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_in,
    input logic              a_par_in,
    input logic [DATA_W-1:0] a_out,
    input logic              a_par_out,
    input logic              a_oe,
    input logic [DATA_W-1:0] b_in,
    input logic              b_par_in,
    input logic [DATA_W-1:0] b_out,
    input logic              b_par_out,
    input logic              b_oe,
    input logic              drv_a_n,
    input logic              drv_b_n,
    input logic              pass_sel,
    input logic              odd_sel,
    input logic              a_le,
    input logic              b_le,
    input logic              a_err_n,
    input logic              b_err_n,
    input logic              oe_clash
);

    assert_dir_b2a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_a_n && drv_b_n) |-> (a_oe && !b_oe && !oe_clash));

    assert_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_a_n && !drv_b_n) |-> (!a_oe && !b_oe && oe_clash));

    assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_le) && !$past(a_oe) && pass_sel && b_oe)
        |-> ({b_par_out, b_out} == $past({a_par_in, a_in})));

    assert_gen_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !pass_sel) |-> ((^{b_par_out, b_out}) == odd_sel));

    assert_gen_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !pass_sel) |-> ((^{a_par_out, a_out}) == odd_sel));

    assert_err_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_le) && !$past(a_oe))
        |-> (a_err_n == ((^$past({a_par_in, a_in})) == odd_sel)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a_le) && $stable(odd_sel)) |-> $stable(a_err_n));

    assert_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b_le) && $past(b_oe))
        |-> (b_err_n == ((^$past({b_par_out, b_out})) == odd_sel)));

endmodule

bind parity_xcvr parity_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
    .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .pass_sel(pass_sel), .odd_sel(odd_sel),
    .a_le(a_le), .b_le(b_le), .a_err_n(a_err_n), .b_err_n(b_err_n), .oe_clash(oe_clash)
);

// File: tb/parity_xcvr_bench.sv
`timescale 1ns/1ps
module parity_xcvr_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] a_in, b_in, a_out, b_out;
    logic          a_par_in, b_par_in, a_par_out, b_par_out, a_oe, b_oe;
    logic          drv_a_n, drv_b_n, pass_sel, odd_sel, a_le, b_le;
    logic          a_err_n, b_err_n, oe_clash;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    parity_xcvr #(.DATA_W(DW)) u_parity_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .pass_sel(pass_sel), .odd_sel(odd_sel),
        .a_le(a_le), .b_le(b_le), .a_err_n(a_err_n), .b_err_n(b_err_n), .oe_clash(oe_clash)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected error flag for a 9-bit word: 1 when the ones count matches the sense.
    function automatic bit exp_ok(input logic [DW:0] w, input bit odd);
        return (^w) == odd;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; a_in = '0; b_in = '0; a_par_in = 0; b_par_in = 0;
        drv_a_n = 1; drv_b_n = 1; pass_sel = 1; odd_sel = 0; a_le = 1; b_le = 1;
        tick(); tick();
        // R8: reset clears both registers; even sense sees no error
        chk("R8 a_err_n", a_err_n, 1);
        chk("R8 b_err_n", b_err_n, 1);
        chk("R2 idle a_oe", a_oe, 0);
        chk("R2 idle b_oe", b_oe, 0);
        chk("R2 idle b_out", b_out, 0);
        rst_n = 1;

        // R4, R6: pass mode A to B over all data and parity values
        drv_b_n = 0; drv_a_n = 1; pass_sel = 1; a_le = 1; b_le = 0;
        for (int i = 0; i < 1024; i++) begin
            a_in = i[7:0]; a_par_in = i[8]; odd_sel = i[9];
            tick();
            chk("R2 b_oe", b_oe, 1);
            chk("R4 b_out", b_out, i[7:0]);
            chk("R4 b_par_out", b_par_out, i[8]);
            chk("R6 a_err_n", a_err_n, exp_ok(i[8:0], i[9]));
        end

        // R5: generate mode A to B
        pass_sel = 0;
        for (int i = 0; i < 1024; i++) begin
            a_in = i[7:0]; a_par_in = i[8]; odd_sel = i[9];
            tick();
            chk("R5 b_par_out", b_par_out, (^i[7:0]) ^ i[9]);
            chk("R5 b_out", b_out, i[7:0]);
            chk("R6 a_err_n gen", a_err_n, exp_ok(i[8:0], i[9]));
        end

        // R5, R6: generate mode B to A
        drv_b_n = 1; drv_a_n = 0; a_le = 0; b_le = 1;
        for (int i = 0; i < 1024; i++) begin
            b_in = i[7:0]; b_par_in = i[8]; odd_sel = i[9];
            tick();
            chk("R2 a_oe", a_oe, 1);
            chk("R5 a_out", a_out, i[7:0]);
            chk("R5 a_par_out", a_par_out, (^i[7:0]) ^ i[9]);
            chk("R6 b_err_n", b_err_n, exp_ok(i[8:0], i[9]));
        end

        // R7: loopback into B with a bad word on b_in, both modes
        drv_a_n = 1; drv_b_n = 0; a_le = 1; b_le = 1;
        for (int i = 0; i < 1024; i++) begin
            a_in = i[7:0]; a_par_in = i[8]; odd_sel = i[9]; pass_sel = i[0] ^ i[3];
            b_in = ~i[7:0]; b_par_in = ~(^(~i[7:0]) ^ i[9]);
            tick(); tick();
            chk("R7 b_err_n", b_err_n, pass_sel ? exp_ok(i[8:0], i[9]) : 1);
            chk("R6 a_err_n concurrent", a_err_n, exp_ok(i[8:0], i[9]));
        end

        // R1: hold keeps the driven word when the input changes
        pass_sel = 1; odd_sel = 0; b_le = 0;
        a_in = 8'h5A; a_par_in = 1; tick();
        a_le = 0; a_in = 8'hC3; a_par_in = 0; tick(); tick();
        chk("R1 hold b_out", b_out, 8'h5A);
        chk("R1 hold b_par_out", b_par_out, 1);
        chk("R1 hold a_err_n", a_err_n, exp_ok({1'b1, 8'h5A}, 0));
        a_le = 1; tick();
        chk("R1 load b_out", b_out, 8'hC3);

        // R9: sense and mode changes act without a clock edge
        a_le = 0; pass_sel = 0; odd_sel = 0; #1;
        chk("R9 gen even", b_par_out, ^8'hC3);
        odd_sel = 1; #1;
        chk("R9 gen odd", b_par_out, ~(^8'hC3) & 1'b1);
        chk("R9 err odd", a_err_n, exp_ok({1'b0, 8'hC3}, 1));
        pass_sel = 1; #1;
        chk("R9 pass", b_par_out, 0);
        tick();

        // R3: both requests asserted
        drv_a_n = 0; drv_b_n = 0; #1;
        chk("R3 a_oe", a_oe, 0);
        chk("R3 b_oe", b_oe, 0);
        chk("R3 clash", oe_clash, 1);
        chk("R3 b_out", b_out, 0);
        drv_a_n = 1; drv_b_n = 1; #1;
        chk("R3 clash off", oe_clash, 0);
        chk("R2 idle a_out", a_out, 0);

        // R8: reset in mid-run clears the register
        drv_b_n = 0; pass_sel = 0; odd_sel = 0; rst_n = 0; tick();
        chk("R8 b_out", b_out, 0);
        chk("R8 b_par_out", b_par_out, 0);
        rst_n = 1; tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule